// File: doc/BRIEF.md
# Guarded Clock Divider

This block produces a clock-enable pulse for the synchronous logic of a subsystem. The pulse rate is the input clock divided by a power of two between 1 and 256. Software cannot change the division factor with a single stray store. It must first open a short unlock window with a dedicated write, and then write the new divide code while that window is still open.

The control word is `DATA_W` bits wide. The most significant bit is the unlock request. The low four bits carry the divide code. The bits between them are not used. A new code does not take effect at once. It is held until the divided period in progress ends, so no enable interval is ever cut short. The active code and the state of the unlock window are both visible at the ports.

Top module: `clkdiv_guard`

## Requirements
- R1: After a synchronous active-low reset, the active code is `DEFAULT_CODE` (2, division by 4), the unlock window is closed, and the period counter starts from zero.
- R2: Only a write of exactly 0x80 (bit 7 at one, bits 6:0 at zero) opens the window. Any other write with bit 7 at one is ignored entirely.
- R3: `unlock_open` is high for exactly four cycles after the clock edge that accepted the unlock. A divide write sampled at any of the next four edges is accepted, and one sampled at the fifth edge is rejected.
- R4: Writing 0x80 again while the window is open neither restarts the window nor closes it.
- R5: A write with bit 7 at zero, made while the window is open, closes the window at that edge. Bits 3:0 are taken as the new code and bits 6:4 are ignored.
- R6: A write with bit 7 at zero while the window is closed leaves the active code unchanged.
- R7: Code n (0 to 8) makes `clk_en_out` a one-cycle pulse once every 2^n cycles. Code 0 holds it high every cycle.
- R8: Codes 9 to 15 leave the active code unchanged, but the write still closes the window.
- R9: An accepted code takes effect only after the pulse that ends the current period. That period keeps its old length, and `div_code_out` changes on the edge that follows that pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Control word write strobe |
| wr_data | input | DATA_W | Control word: bit 7 unlock request, bits 3:0 divide code |
| clk_en_out | output | 1 | Divided clock-enable pulse |
| div_code_out | output | CODE_W | Active divide code |
| unlock_open | output | 1 | Unlock window is open |

## Verification
The bench probes the window edges directly. It places a divide write on the fourth and on the fifth edge after the unlock. A window that is one cycle short or one cycle long would then drop a legal write or accept a late one. It re-issues the unlock in mid-window, which exposes a design that restarts or toggles the window. It sends unlock words with extra bits set and reserved codes 9 to 15, which catches a loose decoder that changes the divider. It also changes the code from 16 down to 2 in the middle of a period and measures the gap that spans the change. A design that switched at once would show a shortened gap there, or an early change of `div_code_out`.

// File: rtl/clkdiv_pkg.sv
// Package: shared types for the guarded clock divider.
// Assumes: a control write is classified into exactly one kind per cycle.
package clkdiv_pkg;

    // Classification of one control-word write.
    typedef enum logic [1:0] {
        WR_NONE   = 2'd0,
        WR_UNLOCK = 2'd1,
        WR_DIVIDE = 2'd2,
        WR_DROP   = 2'd3
    } wr_kind_e;

endpackage

// File: rtl/unlock_window.sv
// Module: unlock_window
// Classifies control writes and runs the timed unlock window. It emits a
// load strobe with the new code when a legal divide write arrives inside the
// window.
// Assumes: the unlock bit is the MSB of wr_data and the code sits in the LSBs.
module unlock_window
    import clkdiv_pkg::*;
#(
    parameter int DATA_W    = 8,
    parameter int CODE_W    = 4,
    parameter int MAX_SHIFT = 8,
    parameter int WINDOW    = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic              win_open,
    output logic              code_ld,
    output logic [CODE_W-1:0] code_val
);

    localparam int WCNT_W = $clog2(WINDOW + 1);
    localparam logic [DATA_W-1:0] UNLOCK_WORD = {1'b1, {(DATA_W-1){1'b0}}};

    wr_kind_e          kind;
    logic [WCNT_W-1:0] left_q;

    // Decode the kind of write presented this cycle.
    always_comb begin
        if (!wr_en)
            kind = WR_NONE;
        else if (wr_data[DATA_W-1])
            kind = (wr_data == UNLOCK_WORD) ? WR_UNLOCK : WR_DROP;
        else
            kind = WR_DIVIDE;
    end

    assign win_open = (left_q != '0);
    assign code_val = wr_data[CODE_W-1:0];

    // Accept a divide write only inside the window and only for a legal code.
    always_comb begin
        code_ld = win_open && (kind == WR_DIVIDE)
                  && (int'(code_val) <= MAX_SHIFT);
    end

    // Window counter: loaded by an unlock while closed, counts down while open,
    // cleared by any divide write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            left_q <= '0;
        else if (win_open) begin
            if (kind == WR_DIVIDE)
                left_q <= '0;
            else
                left_q <= left_q - WCNT_W'(1);
        end else if (kind == WR_UNLOCK)
            left_q <= WCNT_W'(WINDOW);
    end

endmodule

// File: rtl/period_gen.sv
// Module: period_gen
// Counts divided periods of 2^code cycles and pulses on the last cycle of
// each period. It holds a requested code until that pulse, so a running
// period is never shortened.
// Assumes: code_ld is raised only for codes 0..MAX_SHIFT.
module period_gen #(
    parameter int CODE_W       = 4,
    parameter int MAX_SHIFT    = 8,
    parameter int DEFAULT_CODE = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              code_ld,
    input  logic [CODE_W-1:0] code_val,
    output logic              tick,
    output logic [CODE_W-1:0] cur_code
);

    localparam int CNT_W = (MAX_SHIFT > 0) ? MAX_SHIFT : 1;

    logic [CNT_W-1:0]  cnt_q;
    logic [CNT_W-1:0]  term;
    logic [CODE_W-1:0] pend_q;
    logic              pend_vld_q;

    // Terminal count of the active period: 2^code - 1 as a mask of low ones.
    always_comb begin
        term = '0;
        for (int i = 0; i < CNT_W; i++)
            term[i] = (i < int'(cur_code));
    end

    assign tick = (cnt_q == term);

    // Advance the period counter and wrap it at the terminal count.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (tick)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + CNT_W'(1);
    end

    // Hold a requested code and apply it at the period boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_code   <= CODE_W'(DEFAULT_CODE);
            pend_q     <= '0;
            pend_vld_q <= 1'b0;
        end else if (tick) begin
            if (code_ld)
                cur_code <= code_val;
            else if (pend_vld_q)
                cur_code <= pend_q;
            pend_vld_q <= 1'b0;
        end else if (code_ld) begin
            pend_q     <= code_val;
            pend_vld_q <= 1'b1;
        end
    end

endmodule

// File: rtl/clkdiv_guard.sv
// Module: clkdiv_guard (top)
// Power-of-two clock-enable divider whose factor can only be changed through
// a timed unlock followed by a divide write.
// Assumes: one control write per cycle at most; clk is the undivided clock.
module clkdiv_guard #(
    parameter int DATA_W       = 8,
    parameter int CODE_W       = 4,
    parameter int MAX_SHIFT    = 8,
    parameter int WINDOW       = 4,
    parameter int DEFAULT_CODE = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic              clk_en_out,
    output logic [CODE_W-1:0] div_code_out,
    output logic              unlock_open
);

    logic              code_ld;
    logic [CODE_W-1:0] code_val;

    unlock_window #(
        .DATA_W   (DATA_W),
        .CODE_W   (CODE_W),
        .MAX_SHIFT(MAX_SHIFT),
        .WINDOW   (WINDOW)
    ) u_window (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .win_open(unlock_open),
        .code_ld (code_ld),
        .code_val(code_val)
    );

    period_gen #(
        .CODE_W      (CODE_W),
        .MAX_SHIFT   (MAX_SHIFT),
        .DEFAULT_CODE(DEFAULT_CODE)
    ) u_period (
        .clk     (clk),
        .rst_n   (rst_n),
        .code_ld (code_ld),
        .code_val(code_val),
        .tick    (clk_en_out),
        .cur_code(div_code_out)
    );

endmodule

// File: rtl/clkdiv_guard_chk.sv
// Module: clkdiv_guard_chk
// Port-level properties of the guarded divider, bound into every instance.
// Assumes: the same parameters as the bound top.
module clkdiv_guard_chk #(
    parameter int DATA_W    = 8,
    parameter int CODE_W    = 4,
    parameter int MAX_SHIFT = 8,
    parameter int WINDOW    = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [DATA_W-1:0] wr_data,
    input logic              clk_en_out,
    input logic [CODE_W-1:0] div_code_out,
    input logic              unlock_open
);

    localparam logic [DATA_W-1:0] UNLOCK_WORD = {1'b1, {(DATA_W-1){1'b0}}};

    logic [7:0] open_run;

    // Count consecutive cycles with the window open, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n)
            open_run <= '0;
        else if (unlock_open)
            open_run <= (open_run == 8'hFF) ? open_run : open_run + 8'd1;
        else
            open_run <= '0;
    end

    p_window_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
        unlock_open |-> (int'(open_run) < WINDOW));

    p_exact_unlock_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(unlock_open) |-> $past(wr_en && (wr_data == UNLOCK_WORD)));

    p_divide_closes_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (unlock_open && wr_en && !wr_data[DATA_W-1]) |=> !unlock_open);

    p_code_legal_r7: assert property (@(posedge clk) disable iff (!rst_n)
        int'(div_code_out) <= MAX_SHIFT);

    p_div1_steady_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (div_code_out == '0) |-> clk_en_out);

    p_switch_at_boundary_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (div_code_out != $past(div_code_out)) |-> $past(clk_en_out));

endmodule

bind clkdiv_guard clkdiv_guard_chk #(
    .DATA_W   (DATA_W),
    .CODE_W   (CODE_W),
    .MAX_SHIFT(MAX_SHIFT),
    .WINDOW   (WINDOW)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .wr_data     (wr_data),
    .clk_en_out  (clk_en_out),
    .div_code_out(div_code_out),
    .unlock_open (unlock_open)
);

// File: tb/tb_clkdiv_guard.sv
module tb_clkdiv_guard;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       clk_en_out;
    logic [3:0] div_code_out;
    logic       unlock_open;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    int last_pulse = 0;
    int last_gap = 0;
    bit done = 1'b0;
    int model_code;

    clkdiv_guard dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .clk_en_out(clk_en_out), .div_code_out(div_code_out),
        .unlock_open(unlock_open)
    );

    always #4 clk = ~clk;

    // Record the gap between successive enable pulses.
    always @(negedge clk) begin
        cyc++;
        if (rst_n && clk_en_out) begin
            last_gap   = cyc - last_pulse;
            last_pulse = cyc;
        end
    end

    // Vectors: {mode[1:0], data[7:0]}; mode 0 unlock then write,
    // mode 1 write only, mode 2 bad unlock (0x81) then write.
    localparam logic [9:0] VEC [10] = '{
        {2'd0, 8'h00}, {2'd0, 8'h08}, {2'd0, 8'h03}, {2'd0, 8'h09},
        {2'd1, 8'h05}, {2'd2, 8'h05}, {2'd0, 8'h75}, {2'd0, 8'h0F},
        {2'd0, 8'h01}, {2'd0, 8'h07}
    };

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] d);
        wr_en = 1'b1;
        wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        wr_data = 8'h00;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        idle(3);
        rst_n = 1'b1;
        @(negedge clk);
        model_code = 2;
    endtask

    task automatic set_code(input int c);
        wr(8'h80);
        wr(8'(c));
        idle(600);
    endtask

    initial begin
        do_reset();
        // R1: reset state.
        chk("R1 code", int'(div_code_out), 2);
        chk("R1 open", int'(unlock_open), 0);
        chk("R1 enable", int'(clk_en_out), 0);
        idle(20);
        chk("R7 default gap", last_gap, 4);

        // Table walk over modes and codes (R2, R5, R6, R7, R8).
        foreach (VEC[i]) begin
            logic [1:0] m;
            logic [7:0] d;
            m = VEC[i][9:8];
            d = VEC[i][7:0];
            if (m == 2'd0) wr(8'h80);
            if (m == 2'd2) wr(8'h81);
            wr(d);
            if (m == 2'd0 && !d[7] && d[3:0] <= 4'd8) model_code = int'(d[3:0]);
            idle(600);
            chk("R5/R6/R8 vector code", int'(div_code_out), model_code);
            chk("R7 vector gap", last_gap, 1 << model_code);
        end

        // R2: unlock words with extra bits never open the window.
        wr(8'h90);
        chk("R2 0x90 open", int'(unlock_open), 0);
        wr(8'hFF);
        chk("R2 0xFF open", int'(unlock_open), 0);

        // R3: window length exactly four cycles.
        wr(8'h80);
        chk("R3 open at 1", int'(unlock_open), 1);
        idle(3);
        chk("R3 open at 4", int'(unlock_open), 1);
        idle(1);
        chk("R3 closed at 5", int'(unlock_open), 0);

        // R3: divide write on the fourth edge is accepted.
        wr(8'h80);
        idle(3);
        wr(8'h02);
        idle(600);
        chk("R3 fourth edge accepted", int'(div_code_out), 2);

        // R3: divide write on the fifth edge is rejected.
        wr(8'h80);
        idle(4);
        wr(8'h06);
        idle(600);
        chk("R3 fifth edge rejected", int'(div_code_out), 2);

        // R4: second unlock neither extends nor clears.
        wr(8'h80);
        idle(1);
        wr(8'h80);
        chk("R4 still open", int'(unlock_open), 1);
        idle(1);
        chk("R4 open at 4", int'(unlock_open), 1);
        idle(1);
        chk("R4 not extended", int'(unlock_open), 0);

        // R8: reserved code closes the window and is ignored.
        wr(8'h80);
        wr(8'h0C);
        chk("R8 window closed", int'(unlock_open), 0);
        idle(600);
        chk("R8 code kept", int'(div_code_out), 2);

        // R9: change from 16 to 2 in mid-period.
        set_code(4);
        while (clk_en_out !== 1'b1) @(negedge clk);
        idle(2);
        wr(8'h80);
        wr(8'h01);
        chk("R9 not immediate", int'(div_code_out), 4);
        for (int k = 0; k < 40 && div_code_out != 4'd1; k++) @(negedge clk);
        chk("R9 switched", int'(div_code_out), 1);
        chk("R9 old period kept", last_gap, 16);
        chk("R9 no pulse at switch", int'(clk_en_out), 0);
        idle(10);
        chk("R9 new gap", last_gap, 2);

        // R1: reset in mid-run restores the default.
        set_code(6);
        do_reset();
        chk("R1 rerun code", int'(div_code_out), 2);
        chk("R1 rerun open", int'(unlock_open), 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog(all) actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule